// File: doc/BRIEF.md
# Error-Second Performance Classifier

This block grades a bit-error measurement one second at a time. A one-second strobe marks the end of each second. A pulse input reports each errored bit. A loss flag reports loss of signal or loss of pattern lock. Once a start strobe arrives, every later second is graded as available or unavailable. Available seconds are graded again as error-free or errored, and an errored second is also severely errored when its error ratio is worse than 1e-3 or when it saw a loss.

The availability state changes only after a run of ten seconds of the opposite quality. Those ten seconds are then graded as belonging to the new state. To make that exact, seconds whose grade is still open are held back until the run is either confirmed or broken, and only then do they reach the counters. Degraded minutes are built from consecutive groups of sixty seconds that are available and not severely errored. A group whose summed error count shows an average ratio of 1e-6 or worse adds one degraded minute.

The line rate is a parameter (default 2.048 Mbit/s), and the thresholds are derived from it. All counters are 32 bits wide and saturate. They change on the second clock edge after the strobe that closes a second.

Top module: `perf_second_classifier`

## Requirements
- R1: Before the first `start_i`, seconds are not counted. A `start_i` pulse clears all six counters to 0 and sets `avail_o` to 1 on the next clock edge.
- R2: While available, ten consecutive bad seconds clear `avail_o` and add 10 to the unavailable counter. A run of nine bad seconds that is followed by a good second adds those nine to the available, errored and severely errored counters, and `avail_o` stays 1.
- R3: While unavailable, ten consecutive good seconds set `avail_o` and add 10 to the available counter, split between error-free and errored. A shorter good run that ends with a bad second adds the whole run, plus that bad second, to the unavailable counter. Counters stay unchanged while a run is still open.
- R4: A second is bad when its errored-bit count exceeds 2048 or when `sig_loss_i` was high in any cycle of it.
- R5: An available second with zero errors and no loss is error-free. Any other available second is errored. The available count always equals error-free plus errored, and severely errored seconds are a subset of errored seconds.
- R6: A second with exactly 2048 errored bits is errored but not severely errored.
- R7: Available, not severely errored seconds are grouped consecutively in sixes of ten (60). A group with a total error count of at least 123 adds one degraded minute, and a group with 122 adds none. Severely errored and unavailable seconds are left out of the groups, and an unfinished group adds nothing.
- R8: `avail_o` shows the current availability state. It is 1 from start until a confirmed entry into unavailable time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin measurement; clears counters |
| sec_tick_i | input | 1 | One-cycle strobe closing the current second |
| bit_err_i | input | 1 | One errored bit this cycle |
| sig_loss_i | input | 1 | Signal or pattern lock lost this cycle |
| avail_o | output | 1 | Currently in available time |
| as_cnt_o | output | 32 | Available seconds |
| uas_cnt_o | output | 32 | Unavailable seconds |
| efs_cnt_o | output | 32 | Error-free seconds |
| es_cnt_o | output | 32 | Errored seconds |
| ses_cnt_o | output | 32 | Severely errored seconds |
| dm_cnt_o | output | 32 | Degraded minutes |

## Verification
A wrong count of open run seconds shows up one second late at the latest. Either the availability flag moves after nine or eleven seconds, or the held seconds arrive at the wrong counters when the run ends, and this appears two cycles after the strobe that decides the run. A wrong per-second error total, or a wrong threshold, turns up either in the severely errored count at the 2048/2049 boundary or in the degraded-minute count, and the latter only when a sixty-second group closes. The groups are therefore driven right up to their last second with totals of 122 and 123. A held second that is lost or counted twice breaks the rule that available equals error-free plus errored, at the same cycle the run is committed.

// File: rtl/esc_pkg.sv
package esc_pkg;
    localparam int NUM_CNT = 6;
    localparam int CNT_AS  = 0;
    localparam int CNT_UAS = 1;
    localparam int CNT_EFS = 2;
    localparam int CNT_ES  = 3;
    localparam int CNT_SES = 4;
    localparam int CNT_DM  = 5;
endpackage

// File: rtl/esc_second_acc.sv
// Accumulates one second of errors and loss; emits the closed second's result.
module esc_second_acc #(
    parameter int ERR_MAX = 2049,
    parameter int ERR_W   = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             tick_i,
    input  logic             bit_err_i,
    input  logic             loss_i,
    output logic             done_o,
    output logic [ERR_W-1:0] errs_o,
    output logic             bad_o
);
    typedef struct packed {
        logic [ERR_W-1:0] cnt;
        logic             loss;
        logic             done;
        logic [ERR_W-1:0] errs;
        logic             bad;
    } acc_t;

    acc_t acc_d, acc_q;
    logic [ERR_W-1:0] cnt_nx;

    always_comb begin
        cnt_nx = (acc_q.cnt == ERR_W'(ERR_MAX) || !bit_err_i) ? acc_q.cnt : acc_q.cnt + 1'b1;
        acc_d      = acc_q;
        acc_d.done = 1'b0;
        if (clr_i) begin
            acc_d = '0;
        end else if (tick_i) begin
            acc_d.done = 1'b1;
            acc_d.errs = cnt_nx;
            acc_d.bad  = acc_q.loss | loss_i | (cnt_nx == ERR_W'(ERR_MAX));
            acc_d.cnt  = '0;
            acc_d.loss = 1'b0;
        end else begin
            acc_d.cnt  = cnt_nx;
            acc_d.loss = acc_q.loss | loss_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign done_o = acc_q.done;
    assign errs_o = acc_q.errs;
    assign bad_o  = acc_q.bad;
endmodule

// File: rtl/esc_sat_counter.sv
// Saturating counter with a multi-unit increment and synchronous clear.
module esc_sat_counter #(
    parameter int W     = 32,
    parameter int INC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [INC_W-1:0] inc_i,
    output logic [W-1:0]     q_o
);
    logic [W-1:0] q_d, q_q;
    logic [W:0]   sum;

    always_comb begin
        sum = {1'b0, q_q} + (W+1)'(inc_i);
        if (clr_i)       q_d = '0;
        else if (sum[W]) q_d = '1;
        else             q_d = sum[W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign q_o = q_q;
endmodule

// File: rtl/perf_second_classifier.sv
module perf_second_classifier #(
    parameter int LINE_RATE = 2048000,
    parameter int WIN       = 10,
    parameter int MIN_SECS  = 60,
    parameter int CNT_W     = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             sec_tick_i,
    input  logic             bit_err_i,
    input  logic             sig_loss_i,
    output logic             avail_o,
    output logic [CNT_W-1:0] as_cnt_o,
    output logic [CNT_W-1:0] uas_cnt_o,
    output logic [CNT_W-1:0] efs_cnt_o,
    output logic [CNT_W-1:0] es_cnt_o,
    output logic [CNT_W-1:0] ses_cnt_o,
    output logic [CNT_W-1:0] dm_cnt_o
);
    import esc_pkg::*;

    localparam int    SES_THR = LINE_RATE / 1000;
    localparam int    ERR_W   = $clog2(SES_THR + 2);
    localparam longint DM_L   = (longint'(MIN_SECS) * longint'(LINE_RATE) + 64'd999999) / 64'd1000000;
    localparam int    DM_THR  = int'(DM_L);
    localparam int    BE_W    = $clog2(DM_THR + 1);
    localparam int    BS_W    = $clog2(MIN_SECS + 1);
    localparam int    PEND_W  = $clog2(WIN);
    localparam int    INC_W   = $clog2(WIN + 1);
    localparam int    SUM_W   = BE_W + ERR_W + 1;

    typedef struct packed {
        logic                       running;
        logic                       avail;
        logic [PEND_W-1:0]          pend;
        logic [WIN-1:0][ERR_W-1:0]  pend_errs;
        logic [BS_W-1:0]            blk_secs;
        logic [BE_W-1:0]            blk_errs;
    } st_t;

    typedef struct packed {
        logic            hit;
        logic [BS_W-1:0] secs;
        logic [BE_W-1:0] errs;
    } blk_t;

    st_t st_d, st_q;
    logic [NUM_CNT-1:0][INC_W-1:0] inc;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt;
    logic                          sec_done, sec_bad;
    logic [ERR_W-1:0]              sec_errs;

    esc_second_acc #(.ERR_MAX(SES_THR + 1), .ERR_W(ERR_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr_i(start_i), .tick_i(sec_tick_i),
        .bit_err_i(bit_err_i), .loss_i(sig_loss_i),
        .done_o(sec_done), .errs_o(sec_errs), .bad_o(sec_bad)
    );

    // One good available second joins the open sixty-second group.
    function automatic blk_t blk_next(blk_t cur, logic [ERR_W-1:0] e);
        blk_t            n;
        logic [SUM_W-1:0] sum;
        sum    = SUM_W'(cur.errs) + SUM_W'(e);
        n.hit  = 1'b0;
        n.errs = (sum >= SUM_W'(DM_THR)) ? BE_W'(DM_THR) : BE_W'(sum);
        n.secs = cur.secs + 1'b1;
        if (n.secs == BS_W'(MIN_SECS)) begin
            n.hit  = (n.errs == BE_W'(DM_THR));
            n.secs = '0;
            n.errs = '0;
        end
        return n;
    endfunction

    always_comb begin
        blk_t             blk;
        logic [INC_W-1:0] pend_x;
        logic [INC_W-1:0] zero_n;
        logic [INC_W-1:0] dm_n;
        logic [ERR_W-1:0] e;
        st_d   = st_q;
        inc    = '0;
        blk    = '{hit: 1'b0, secs: st_q.blk_secs, errs: st_q.blk_errs};
        pend_x = INC_W'(st_q.pend);
        zero_n = '0;
        dm_n   = '0;
        e      = '0;
        if (start_i) begin
            st_d         = '0;
            st_d.running = 1'b1;
            st_d.avail   = 1'b1;
        end else if (st_q.running && sec_done) begin
            if (st_q.avail) begin
                if (sec_bad) begin
                    if (st_q.pend == PEND_W'(WIN - 1)) begin
                        inc[CNT_UAS] = INC_W'(WIN);
                        st_d.avail   = 1'b0;
                        st_d.pend    = '0;
                    end else begin
                        st_d.pend = st_q.pend + 1'b1;
                    end
                end else begin
                    blk          = blk_next(blk, sec_errs);
                    inc[CNT_AS]  = pend_x + 1'b1;
                    inc[CNT_SES] = pend_x;
                    inc[CNT_ES]  = pend_x + INC_W'(sec_errs != '0);
                    inc[CNT_EFS] = INC_W'(sec_errs == '0);
                    inc[CNT_DM]  = INC_W'(blk.hit);
                    st_d.pend    = '0;
                end
            end else begin
                if (sec_bad) begin
                    inc[CNT_UAS] = pend_x + 1'b1;
                    st_d.pend    = '0;
                end else if (st_q.pend == PEND_W'(WIN - 1)) begin
                    for (int i = 0; i < WIN; i++) begin
                        e      = (i == WIN - 1) ? sec_errs : st_q.pend_errs[i];
                        blk    = blk_next(blk, e);
                        zero_n = zero_n + INC_W'(e == '0);
                        dm_n   = dm_n + INC_W'(blk.hit);
                    end
                    inc[CNT_AS]  = INC_W'(WIN);
                    inc[CNT_EFS] = zero_n;
                    inc[CNT_ES]  = INC_W'(WIN) - zero_n;
                    inc[CNT_DM]  = dm_n;
                    st_d.avail   = 1'b1;
                    st_d.pend    = '0;
                end else begin
                    st_d.pend_errs[st_q.pend] = sec_errs;
                    st_d.pend                 = st_q.pend + 1'b1;
                end
            end
            st_d.blk_secs = blk.secs;
            st_d.blk_errs = blk.errs;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        esc_sat_counter #(.W(CNT_W), .INC_W(INC_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .clr_i(start_i), .inc_i(inc[g]), .q_o(cnt[g])
        );
    end

    assign avail_o   = st_q.avail | ~st_q.running;
    assign as_cnt_o  = cnt[CNT_AS];
    assign uas_cnt_o = cnt[CNT_UAS];
    assign efs_cnt_o = cnt[CNT_EFS];
    assign es_cnt_o  = cnt[CNT_ES];
    assign ses_cnt_o = cnt[CNT_SES];
    assign dm_cnt_o  = cnt[CNT_DM];
endmodule

// File: rtl/esc_checker.sv
module esc_checker #(
    parameter int WIN   = 10,
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             avail_o,
    input logic [CNT_W-1:0] as_cnt_o,
    input logic [CNT_W-1:0] uas_cnt_o,
    input logic [CNT_W-1:0] efs_cnt_o,
    input logic [CNT_W-1:0] es_cnt_o,
    input logic [CNT_W-1:0] ses_cnt_o,
    input logic [CNT_W-1:0] dm_cnt_o
);
    p_start_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (as_cnt_o == '0 && uas_cnt_o == '0 && efs_cnt_o == '0 &&
                     es_cnt_o == '0 && ses_cnt_o == '0 && dm_cnt_o == '0 && avail_o));

    p_enter_unavail_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(avail_o) |-> (uas_cnt_o == $past(uas_cnt_o) + CNT_W'(WIN)));

    p_leave_unavail_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (avail_o && !$past(avail_o) && !$past(start_i)) |->
            (as_cnt_o == $past(as_cnt_o) + CNT_W'(WIN) && $stable(uas_cnt_o)));

    p_split_r5: assert property (@(posedge clk) disable iff (!rst_n)
        as_cnt_o == efs_cnt_o + es_cnt_o);

    p_ses_subset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ses_cnt_o <= es_cnt_o);

    p_dm_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(start_i) |-> (dm_cnt_o == $past(dm_cnt_o) || dm_cnt_o == $past(dm_cnt_o) + 1'b1));
endmodule

bind perf_second_classifier esc_checker #(.WIN(WIN), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .avail_o(avail_o),
    .as_cnt_o(as_cnt_o), .uas_cnt_o(uas_cnt_o), .efs_cnt_o(efs_cnt_o),
    .es_cnt_o(es_cnt_o), .ses_cnt_o(ses_cnt_o), .dm_cnt_o(dm_cnt_o)
);

// File: tb/perf_second_classifier_tb.sv
module perf_second_classifier_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, tick = 1'b0, berr = 1'b0, loss = 1'b0;
    logic        avail;
    logic [31:0] as_c, uas_c, efs_c, es_c, ses_c, dm_c;

    int  checks = 0, errors = 0;
    bit  pending = 1'b0, finished = 1'b0;

    typedef struct {
        string       tag;
        logic [31:0] v_as, v_uas, v_efs, v_es, v_ses, v_dm;
        logic        v_av;
    } exp_t;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    perf_second_classifier u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .sec_tick_i(tick),
        .bit_err_i(berr), .sig_loss_i(loss), .avail_o(avail),
        .as_cnt_o(as_c), .uas_cnt_o(uas_c), .efs_cnt_o(efs_c),
        .es_cnt_o(es_c), .ses_cnt_o(ses_c), .dm_cnt_o(dm_c)
    );

    task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Monitor: pops expected snapshots and compares them with the ports.
    always begin
        @(negedge clk);
        if (exp_q.size() > 0) begin
            exp_t it;
            it = exp_q.pop_front();
            cmp(it.tag, "avail", {31'd0, avail}, {31'd0, it.v_av});
            cmp(it.tag, "as",  as_c,  it.v_as);
            cmp(it.tag, "uas", uas_c, it.v_uas);
            cmp(it.tag, "efs", efs_c, it.v_efs);
            cmp(it.tag, "es",  es_c,  it.v_es);
            cmp(it.tag, "ses", ses_c, it.v_ses);
            cmp(it.tag, "dm",  dm_c,  it.v_dm);
            pending = 1'b0;
        end
    end

    task automatic expect_snap(input string tag, input int a, input int u, input int f,
                               input int e, input int s, input int d, input bit av);
        exp_t it;
        repeat (3) @(negedge clk);
        it.tag = tag; it.v_as = a; it.v_uas = u; it.v_efs = f;
        it.v_es = e; it.v_ses = s; it.v_dm = d; it.v_av = av;
        pending = 1'b1;
        exp_q.push_back(it);
        wait (!pending);
    endtask

    task automatic run_sec(input int nerr, input bit lo);
        for (int k = 0; k < nerr; k++) begin
            @(negedge clk); berr = 1'b1;
        end
        @(negedge clk); berr = 1'b0; loss = lo;
        @(negedge clk); loss = 1'b0;
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic run_n(input int n, input int nerr, input bit lo);
        for (int k = 0; k < n; k++) run_sec(nerr, lo);
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_snap("reset", 0, 0, 0, 0, 0, 0, 1'b1);
        // R1: seconds before start are not counted
        run_n(2, 7, 1'b1);
        expect_snap("R1 pre-start", 0, 0, 0, 0, 0, 0, 1'b1);
        pulse_start();
        expect_snap("R1 start", 0, 0, 0, 0, 0, 0, 1'b1);
        run_n(3, 0, 1'b0);
        expect_snap("R5 clean", 3, 0, 3, 0, 0, 0, 1'b1);
        run_sec(5, 1'b0);
        expect_snap("R5 errored", 4, 0, 3, 1, 0, 0, 1'b1);
        run_sec(2048, 1'b0);
        expect_snap("R6 2048 errors", 5, 0, 3, 2, 0, 0, 1'b1);
        run_sec(2049, 1'b0);
        expect_snap("R4 2049 pending", 5, 0, 3, 2, 0, 0, 1'b1);
        run_sec(0, 1'b0);
        expect_snap("R4 2049 severe", 7, 0, 4, 3, 1, 0, 1'b1);
        run_n(9, 0, 1'b1);
        expect_snap("R2 nine pending", 7, 0, 4, 3, 1, 0, 1'b1);
        run_sec(0, 1'b0);
        expect_snap("R2 nine as severe", 17, 0, 5, 12, 10, 0, 1'b1);
        run_n(10, 0, 1'b1);
        expect_snap("R2 R8 enter unavailable", 17, 10, 5, 12, 10, 0, 1'b0);
        run_n(4, 0, 1'b0);
        run_sec(0, 1'b1);
        expect_snap("R3 broken good run", 17, 15, 5, 12, 10, 0, 1'b0);
        run_n(9, 0, 1'b0);
        expect_snap("R3 open run", 17, 15, 5, 12, 10, 0, 1'b0);
        run_sec(3, 1'b0);
        expect_snap("R3 R8 leave unavailable", 27, 15, 14, 13, 10, 0, 1'b1);
        // group holds 17 seconds, errors already past threshold
        run_n(42, 0, 1'b0);
        expect_snap("R7 unfinished group", 69, 15, 56, 13, 10, 0, 1'b1);
        run_sec(0, 1'b0);
        expect_snap("R7 degraded group", 70, 15, 57, 13, 10, 1, 1'b1);
        run_sec(122, 1'b0);
        run_sec(2049, 1'b0);
        run_n(59, 0, 1'b0);
        expect_snap("R7 122 errors and severe excluded", 131, 15, 116, 15, 11, 1, 1'b1);
        run_sec(123, 1'b0);
        run_n(58, 0, 1'b0);
        expect_snap("R7 123 before close", 190, 15, 174, 16, 11, 1, 1'b1);
        run_sec(0, 1'b0);
        expect_snap("R7 123 errors", 191, 15, 175, 16, 11, 2, 1'b1);
        run_n(10, 0, 1'b1);
        expect_snap("R2 second entry", 191, 25, 175, 16, 11, 2, 1'b0);
        pulse_start();
        expect_snap("R1 restart", 0, 0, 0, 0, 0, 0, 1'b1);
        finish_run();
    end
endmodule